// File: doc/BRIEF.md
# SD DAT0 Transfer Status Checker

This block watches the DAT0 line of an SD card interface, one sample per clock, and judges each transfer that software or a transfer engine starts. Three kinds of transfer are supported. A read block is a start bit, a whole number of data bytes, a 16-bit CRC and an end bit. A write status is the short response token the card returns after a written block, followed by a busy period. A busy-only transfer is the busy period that follows a command with a busy response.

For each transfer the block raises a single done pulse. Any data CRC error, data end-bit error or busy timeout is reported as a pulse in that same cycle. The controller pulses `start` with the mode, the block length in bytes and the busy limit. The block then needs no further control until done, and it returns to idle afterwards.

Top module: `sd_dat0_checker`

## Requirements
- R1: While and after reset, `done`, `crc_err`, `end_err` and `tmo_err` are all low until a transfer completes.
- R2: In read mode (`mode` = 0) the block waits for a 0 start bit. It then takes `blk_bytes`*8 data bits MSB first, 16 CRC bits MSB first and one end bit. `done` is high in the cycle after the end bit is sampled. `blk_bytes` must be 1 or more.
- R3: Read data is protected by CRC16 with polynomial x^16+x^12+x^5+1 and an initial value of 0, computed over the data bits only. If the received CRC differs from the computed one, `crc_err` pulses with `done`.
- R4: In read mode, a 0 sampled at the end-bit position pulses `end_err` with `done`.
- R5: In write mode (`mode` = 1) the block waits for a 0 start bit. It then takes three status bits MSB first and one end bit. Any status value other than binary 010 pulses `crc_err` with the transfer's `done`.
- R6: In write mode, a 0 sampled at the token's end-bit position pulses `end_err` with the transfer's `done`.
- R7: Busy starts in the cycle after the token end bit (write mode) or the cycle after `start` (mode 2 or 3). DAT0 low means busy. The first high sample ends busy, and `done` follows one cycle later.
- R8: With `busy_limit` = L, up to L low busy samples are allowed. The (L+1)th low sample pulses `tmo_err` with `done` one cycle later and ends the transfer. The busy counter advances only on low samples.
- R9: Every transfer produces exactly one single-cycle `done` pulse. No error output is high in a cycle without `done`.
- R10: A `start` pulse that arrives while a transfer is in progress is ignored and does not change that transfer's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one DAT0 sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| mode | input | 2 | 0 read block, 1 write status plus busy, 2 or 3 busy only |
| blk_bytes | input | LEN_W | Read block length in bytes |
| busy_limit | input | TO_W | Largest allowed number of low busy samples |
| dat0 | input | 1 | Sampled DAT0 line |
| done | output | 1 | Transfer finished pulse |
| crc_err | output | 1 | Data CRC error pulse |
| end_err | output | 1 | Data end-bit error pulse |
| tmo_err | output | 1 | Busy timeout pulse |

## Verification
The bench builds the checker with LEN_W = 4 and TO_W = 6. Blocks of 1 and 15 bytes therefore cover both ends of the length range in a few hundred cycles. Busy limits of 0, small values and the maximum of 63 can each be run up to one sample past the limit. These settings make the exact-limit and limit-plus-one busy cases cheap to run, along with the single-byte and full-length CRC cases.

// File: rtl/sd_chk_pkg.sv
package sd_chk_pkg;

    typedef enum logic [1:0] {
        MODE_READ     = 2'd0,
        MODE_WRITE    = 2'd1,
        MODE_BUSY     = 2'd2,
        MODE_BUSY_ALT = 2'd3
    } chk_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SB,
        ST_DATA,
        ST_CRCB,
        ST_ENDB,
        ST_TOK,
        ST_TOK_END,
        ST_BUSY
    } chk_state_e;

    typedef struct packed {
        logic done;
        logic crc_err;
        logic end_err;
        logic tmo_err;
    } chk_result_t;

    localparam logic [15:0] CRC16_POLY = 16'h1021;
    localparam logic [2:0]  TOKEN_GOOD = 3'b010;

    function automatic logic [15:0] crc16_step(input logic [15:0] cur, input logic din);
        logic fb;
        fb = cur[15] ^ din;
        return {cur[14:0], 1'b0} ^ (fb ? CRC16_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/sd_crc16_serial.sv
module sd_crc16_serial
    import sd_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        shift,
    input  logic        din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc <= 16'h0000;
        end else if (shift) begin
            crc <= crc16_step(crc, din);
        end
    end
endmodule

// File: rtl/sd_busy_timer.sv
module sd_busy_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            active,
    input  logic            dat0,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] low_cnt;

    assign expired = active && !dat0 && (low_cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            low_cnt <= '0;
        end else if (active && !dat0 && !expired) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sd_dat0_checker.sv
module sd_dat0_checker
    import sd_chk_pkg::*;
#(
    parameter int LEN_W = 10,
    parameter int TO_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [LEN_W-1:0] blk_bytes,
    input  logic [TO_W-1:0]  busy_limit,
    input  logic             dat0,
    output logic             done,
    output logic             crc_err,
    output logic             end_err,
    output logic             tmo_err
);
    localparam int CNT_W = LEN_W + 3;

    chk_state_e       st;
    logic             is_read_q;
    logic [CNT_W-1:0] nbits_q;
    logic [CNT_W-1:0] bitcnt;
    logic [TO_W-1:0]  limit_q;
    logic [2:0]       tok_q;
    logic             tok_bad_q;
    logic             tok_end_bad_q;
    chk_result_t      res;

    logic        accept;
    logic        crc_shift;
    logic [15:0] crc_val;
    logic        busy_active;
    logic        busy_expired;

    assign accept      = (st == ST_IDLE) && start;
    assign crc_shift   = (st == ST_DATA) || (st == ST_CRCB);
    assign busy_active = (st == ST_BUSY);

    sd_crc16_serial u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .shift (crc_shift),
        .din   (dat0),
        .crc   (crc_val)
    );

    sd_busy_timer #(.TO_W(TO_W)) u_busy (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .active  (busy_active),
        .dat0    (dat0),
        .limit   (limit_q),
        .expired (busy_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ST_IDLE;
            is_read_q     <= 1'b0;
            nbits_q       <= '0;
            bitcnt        <= '0;
            limit_q       <= '0;
            tok_q         <= '0;
            tok_bad_q     <= 1'b0;
            tok_end_bad_q <= 1'b0;
            res           <= '0;
        end else begin
            res <= '0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        is_read_q     <= (chk_mode_e'(mode) == MODE_READ);
                        nbits_q       <= {blk_bytes, 3'b000};
                        limit_q       <= busy_limit;
                        tok_bad_q     <= 1'b0;
                        tok_end_bad_q <= 1'b0;
                        bitcnt        <= '0;
                        if (chk_mode_e'(mode) == MODE_READ || chk_mode_e'(mode) == MODE_WRITE)
                            st <= ST_WAIT_SB;
                        else
                            st <= ST_BUSY;
                    end
                end
                ST_WAIT_SB: begin
                    if (!dat0) begin
                        bitcnt <= '0;
                        st     <= is_read_q ? ST_DATA : ST_TOK;
                    end
                end
                ST_DATA: begin
                    if (bitcnt == nbits_q - 1'b1) begin
                        bitcnt <= '0;
                        st     <= ST_CRCB;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_CRCB: begin
                    if (bitcnt == CNT_W'(15)) begin
                        bitcnt <= '0;
                        st     <= ST_ENDB;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_ENDB: begin
                    res.done    <= 1'b1;
                    res.crc_err <= (crc_val != 16'h0000);
                    res.end_err <= !dat0;
                    st          <= ST_IDLE;
                end
                ST_TOK: begin
                    tok_q <= {tok_q[1:0], dat0};
                    if (bitcnt == CNT_W'(2)) begin
                        bitcnt <= '0;
                        st     <= ST_TOK_END;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_TOK_END: begin
                    tok_bad_q     <= (tok_q != TOKEN_GOOD);
                    tok_end_bad_q <= !dat0;
                    st            <= ST_BUSY;
                end
                ST_BUSY: begin
                    if (dat0 || busy_expired) begin
                        res.done    <= 1'b1;
                        res.crc_err <= tok_bad_q;
                        res.end_err <= tok_end_bad_q;
                        res.tmo_err <= busy_expired;
                        st          <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign done    = res.done;
    assign crc_err = res.crc_err;
    assign end_err = res.end_err;
    assign tmo_err = res.tmo_err;

endmodule

// File: rtl/sd_dat0_checker_sva.sv
module sd_dat0_checker_sva (
    input logic clk,
    input logic rst,
    input logic dat0,
    input logic done,
    input logic crc_err,
    input logic end_err,
    input logic tmo_err
);
    assert_err_needs_done_R9: assert property (@(posedge clk) disable iff (rst)
        (crc_err || end_err || tmo_err) |-> done);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_tmo_on_low_R8: assert property (@(posedge clk) disable iff (rst)
        tmo_err |-> !$past(dat0));

    assert_clean_end_high_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !tmo_err && !end_err) |-> $past(dat0));
endmodule

bind sd_dat0_checker sd_dat0_checker_sva u_sva (
    .clk     (clk),
    .rst     (rst),
    .dat0    (dat0),
    .done    (done),
    .crc_err (crc_err),
    .end_err (end_err),
    .tmo_err (tmo_err)
);

// File: tb/sd_dat0_checker_test.sv
module sd_dat0_checker_test;
    localparam int LEN_W = 4;
    localparam int TO_W  = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic [LEN_W-1:0] blk_bytes = '0;
    logic [TO_W-1:0]  busy_limit = '0;
    logic             dat0 = 1'b1;
    logic             done, crc_err, end_err, tmo_err;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    sd_dat0_checker #(.LEN_W(LEN_W), .TO_W(TO_W)) uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .blk_bytes(blk_bytes), .busy_limit(busy_limit), .dat0(dat0),
        .done(done), .crc_err(crc_err), .end_err(end_err), .tmo_err(tmo_err)
    );

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: pops expected {crc,end,tmo} on each done (R9)
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9: unexpected done, got %b expected none", {crc_err, end_err, tmo_err});
                end else begin
                    automatic logic [2:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if ({crc_err, end_err, tmo_err} !== e) begin
                        errors++;
                        $display("FAIL %s: flags {crc,end,tmo} got %b expected %b", t, {crc_err, end_err, tmo_err}, e);
                    end
                end
            end else if (crc_err || end_err || tmo_err) begin
                checks++;
                errors++;
                $display("FAIL R9: error without done, got %b expected 000", {crc_err, end_err, tmo_err});
            end
        end
    end

    function automatic logic [15:0] ref_crc(input logic [7:0] d[16], input int n);
        logic [15:0] c = 16'h0;
        for (int i = 0; i < n; i++)
            for (int b = 7; b >= 0; b--) begin
                logic top = c[15] ^ d[i][b];
                c = c << 1;
                if (top) c = c ^ 16'h1021;
            end
        return c;
    endfunction

    task automatic pulse_start(input logic [1:0] m, input int nb, input int lim);
        @(negedge clk);
        start = 1'b1; mode = m; blk_bytes = LEN_W'(nb); busy_limit = TO_W'(lim); dat0 = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic bit_out(input logic v);
        dat0 = v;
        @(negedge clk);
    endtask

    task automatic settle();
        dat0 = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_read(input int nb, input int seed, input bit bad_crc, input bit bad_end,
                            input bit poke, input string tag);
        logic [7:0] d[16];
        logic [15:0] c;
        int k = 0;
        for (int i = 0; i < 16; i++) d[i] = 8'((seed * 37 + i * 91 + 13) ^ (i << 3));
        c = ref_crc(d, nb);
        exp_q.push_back({bad_crc, bad_end, 1'b0});
        tag_q.push_back(tag);
        pulse_start(2'd0, nb, 0);
        bit_out(1'b1);
        bit_out(1'b0);
        for (int i = 0; i < nb; i++)
            for (int b = 7; b >= 0; b--) begin
                start = (poke && k == 5);
                mode  = 2'd2;
                k++;
                bit_out(d[i][b]);
            end
        start = 1'b0;
        if (bad_crc) c = c ^ 16'h0100;
        for (int b = 15; b >= 0; b--) bit_out(c[b]);
        bit_out(!bad_end);
        settle();
    endtask

    task automatic run_write(input logic [2:0] tok, input bit endbit, input int blen,
                             input int lim, input string tag);
        exp_q.push_back({tok != 3'b010, !endbit, blen > lim});
        tag_q.push_back(tag);
        pulse_start(2'd1, 1, lim);
        bit_out(1'b0);
        for (int b = 2; b >= 0; b--) bit_out(tok[b]);
        bit_out(endbit);
        for (int i = 0; i < blen; i++) bit_out(1'b0);
        settle();
    endtask

    task automatic run_busy(input logic [1:0] m, input int blen, input int lim, input string tag);
        exp_q.push_back({1'b0, 1'b0, blen > lim});
        tag_q.push_back(tag);
        pulse_start(m, 1, lim);
        for (int i = 0; i < blen; i++) bit_out(1'b0);
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, got no end expected end");
        summary_and_end();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({done, crc_err, end_err, tmo_err} !== 4'b0) begin
            errors++;
            $display("FAIL R1: outputs in reset got %b expected 0000", {done, crc_err, end_err, tmo_err});
        end
        rst = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if ({done, crc_err, end_err, tmo_err} !== 4'b0) begin
            errors++;
            $display("FAIL R1: outputs after reset got %b expected 0000", {done, crc_err, end_err, tmo_err});
        end

        run_read(1,  1, 0, 0, 0, "R2 read 1 byte clean");
        run_read(15, 2, 0, 0, 0, "R2 read 15 bytes clean");
        run_read(4,  3, 1, 0, 0, "R3 read crc mismatch");
        run_read(15, 4, 1, 0, 0, "R3 read crc mismatch long");
        run_read(2,  5, 0, 1, 0, "R4 read end bit 0");
        run_read(3,  6, 1, 1, 0, "R3 R4 read both errors");
        run_read(6,  7, 0, 0, 1, "R10 start during read ignored");

        run_write(3'b010, 1, 0, 5, "R5 token good no busy");
        run_write(3'b101, 1, 3, 5, "R5 token bad 101");
        run_write(3'b011, 1, 2, 5, "R5 token bad 011");
        run_write(3'b010, 0, 2, 5, "R6 token end bit 0");
        run_write(3'b010, 1, 5, 5, "R8 write busy at limit");
        run_write(3'b111, 1, 6, 5, "R8 write busy past limit");

        run_busy(2'd2, 0,  4,  "R7 busy none");
        run_busy(2'd2, 7,  10, "R7 busy short");
        run_busy(2'd3, 3,  3,  "R8 busy alt mode at limit");
        run_busy(2'd2, 4,  3,  "R8 busy one past limit");
        run_busy(2'd2, 1,  0,  "R8 zero limit");
        run_busy(2'd2, 63, 63, "R8 max limit exact");
        run_busy(2'd2, 64, 63, "R8 max limit exceeded");

        repeat (5) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: missing done pulses got %0d pending expected 0", exp_q.size());
        end
        summary_and_end();
    end
endmodule